// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock, standing in for an oscillator output, by an integer N. It produces a pulse that lasts one input clock and is meant for a phase detector. A modulus counter acts as the prescaler and counts either P+1 or P input clocks per output cycle. P is 8 or 16, chosen by a select bit. A main counter and a swallow counter step down once per prescaler cycle. While the swallow counter is nonzero, the prescaler uses the long modulus P+1. Once it drains, the prescaler falls back to P. When the main counter runs out, both counters reload and the output pulse fires, so N = P·A + B.

The main count A is supplied as a field that holds A−1. The field is split into an upper and a lower part, which are concatenated upper-first. The swallow count B is given directly. New settings are captured only at the reload boundary. This lets software-style register inputs change at any time without cutting a divide period short.

Top module: `pswal_fbdiv`

## Requirements
- R1: With the main field value f (A = f+1, field = {a_hi_i, a_lo_i}) and swallow value B < A, the distance between consecutive output pulses is P·A + B input clocks.
- R2: psel_i = 0 selects P = 8 (moduli 8/9) and psel_i = 1 selects P = 16 (moduli 16/17). The long modulus P+1 is used for the first B prescaler cycles and P for the rest.
- R3: A swallow value larger than P−1 is treated as P−1. For example, B = 12 with P = 8 behaves as B = 7.
- R4: When B ≥ A, every prescaler cycle uses P+1, so the period is A·(P+1). The output keeps pulsing periodically.
- R5: pulse_o is high for exactly one input clock per period.
- R6: While rst_i is high, pulse_o stays low. After reset, the first period uses A = 13, B = 4 and P = 16, whatever the inputs are, so the first pulse comes 212 clocks after release.
- R7: Input settings take effect only at the clock edge where a pulse is issued. A period already running completes with its old settings.
- R8: Field value 511 gives A = 512 (N = 8192 + B with P = 16). Field value 0 gives A = 1 (N = P, or P+1 when B > 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock being divided |
| rst_i | input | 1 | Synchronous reset, active high |
| a_hi_i | input | 5 | Upper part of the main-count field (A−1) |
| a_lo_i | input | 4 | Lower part of the main-count field (A−1) |
| swallow_i | input | 4 | Swallow count B |
| psel_i | input | 1 | Prescaler pair select: 0 = 8/9, 1 = 16/17 |
| pulse_o | output | 1 | Divided output, one clock wide |

## Verification
The delicate cycle is the one where the main counter wraps. In that cycle the output pulse fires, the settings are captured, and the prescaler reloads with a modulus taken from the newly captured swallow count. The bench provokes this by changing every input in the middle of a long period and again just after a pulse. It then judges the result by measuring each interval between pulses against P·A + B, computed in the bench. Each sweep of swallow values against both prescaler pairs places the swallow drain either before the wrap or, for B ≥ A, exactly on it.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

   // Reset defaults of the divider settings
   localparam int unsigned DEF_A_M1 = 12;   // A = 13
   localparam int unsigned DEF_B    = 4;
   localparam bit          DEF_P_HI = 1'b1; // 16/17 pair

   // Prescaler reload value: modulus minus one
   function automatic int unsigned span_load(input int unsigned lo_log2,
                                             input logic hi,
                                             input logic lng);
      int unsigned m;
      m = (32'd1 << (lo_log2 + (hi ? 1 : 0))) + (lng ? 1 : 0);
      return m - 1;
   endfunction

endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
   parameter int unsigned LO_LOG2 = 3
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ld_hi_i,    // pair for the next prescaler cycle
   input  logic ld_long_i,  // next prescaler cycle uses P+1
   output logic tc_o
);
   import pswal_pkg::*;

   localparam int unsigned HI_MOD = 1 << (LO_LOG2 + 1);
   localparam int unsigned CW     = $clog2(HI_MOD + 1);
   localparam int unsigned RST_LD = span_load(LO_LOG2, DEF_P_HI, (DEF_B != 0));

   logic [CW-1:0] span_q;
   logic [CW-1:0] span_ld;

   always_comb begin
      span_ld = CW'(span_load(LO_LOG2, ld_hi_i, ld_long_i));
   end

   assign tc_o = (span_q == '0);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         span_q <= CW'(RST_LD);
      else if (tc_o)
         span_q <= span_ld;
      else
         span_q <= span_q - 1'b1;
   end

   a_r2_tc_isolated: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o |=> !tc_o);

   a_r2_span_bound: assert property (@(posedge clk_i) disable iff (rst_i)
      span_q <= CW'(HI_MOD));

endmodule

// File: rtl/pswal_count.sv
module pswal_count #(
   parameter int unsigned A_W = 9,
   parameter int unsigned B_W = 4
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           tc_i,
   input  logic [A_W-1:0] a_ld_i,
   input  logic [B_W-1:0] b_ld_i,
   output logic           wrap_o,
   output logic           long_nxt_o
);
   import pswal_pkg::*;

   logic [A_W-1:0] a_rem_q;   // remaining prescaler cycles minus one
   logic [B_W-1:0] b_rem_q;   // remaining long cycles

   assign wrap_o = tc_i && (a_rem_q == '0);

   always_comb begin
      if (wrap_o)
         long_nxt_o = (b_ld_i != '0);
      else
         long_nxt_o = (b_rem_q > B_W'(1));
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         a_rem_q <= A_W'(DEF_A_M1);
         b_rem_q <= B_W'(DEF_B);
      end else if (wrap_o) begin
         a_rem_q <= a_ld_i;
         b_rem_q <= b_ld_i;
      end else if (tc_i) begin
         a_rem_q <= a_rem_q - 1'b1;
         if (b_rem_q != '0)
            b_rem_q <= b_rem_q - 1'b1;
      end
   end

   a_r1_main_step: assert property (@(posedge clk_i) disable iff (rst_i)
      (tc_i && a_rem_q != '0) |=> (a_rem_q == $past(a_rem_q) - 1'b1));

   a_r2_swallow_drain: assert property (@(posedge clk_i) disable iff (rst_i)
      (tc_i && !wrap_o && b_rem_q != '0) |=> (b_rem_q == $past(b_rem_q) - 1'b1));

   a_r4_swallow_floor: assert property (@(posedge clk_i) disable iff (rst_i)
      (!wrap_o && b_rem_q == '0) |=> (b_rem_q == '0));

   a_r2_idle_between: assert property (@(posedge clk_i) disable iff (rst_i)
      !tc_i |=> ($stable(a_rem_q) && $stable(b_rem_q)));

endmodule

// File: rtl/pswal_cfg.sv
module pswal_cfg #(
   parameter int unsigned A_HI_W  = 5,
   parameter int unsigned A_LO_W  = 4,
   parameter int unsigned B_W     = 4,
   parameter int unsigned LO_LOG2 = 3,
   parameter bit          CLAMP   = 1'b1,
   localparam int unsigned A_W    = A_HI_W + A_LO_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wrap_i,
   input  logic [A_HI_W-1:0] a_hi_i,
   input  logic [A_LO_W-1:0] a_lo_i,
   input  logic [B_W-1:0]    b_i,
   input  logic              psel_i,
   output logic              p_hi_q_o,
   output logic              hi_nxt_o,
   output logic [A_W-1:0]    a_nxt_o,
   output logic [B_W-1:0]    b_nxt_o
);
   import pswal_pkg::*;

   localparam int unsigned LO_MOD = 1 << LO_LOG2;

   logic [B_W-1:0] b_lim;

   assign a_nxt_o  = {a_hi_i, a_lo_i};
   assign b_lim    = psel_i ? B_W'(2 * LO_MOD - 1) : B_W'(LO_MOD - 1);
   assign hi_nxt_o = wrap_i ? psel_i : p_hi_q_o;

   generate
      if (CLAMP) begin : g_sat
         assign b_nxt_o = (b_i > b_lim) ? b_lim : b_i;
      end else begin : g_mask
         assign b_nxt_o = b_i & b_lim;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)
         p_hi_q_o <= DEF_P_HI;
      else if (wrap_i)
         p_hi_q_o <= psel_i;
   end

   a_r7_pair_held: assert property (@(posedge clk_i) disable iff (rst_i)
      !wrap_i |=> $stable(p_hi_q_o));

   a_r3_swallow_limit: assert property (@(posedge clk_i) disable iff (rst_i)
      (!psel_i) |-> (b_nxt_o < B_W'(LO_MOD)));

endmodule

// File: rtl/pswal_fbdiv.sv
module pswal_fbdiv #(
   parameter int unsigned A_HI_W  = 5,
   parameter int unsigned A_LO_W  = 4,
   parameter int unsigned B_W     = 4,
   parameter int unsigned LO_LOG2 = 3,
   parameter bit          CLAMP   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [A_HI_W-1:0] a_hi_i,
   input  logic [A_LO_W-1:0] a_lo_i,
   input  logic [B_W-1:0]    swallow_i,
   input  logic              psel_i,
   output logic              pulse_o
);
   localparam int unsigned A_W = A_HI_W + A_LO_W;

   generate
      if (LO_LOG2 < 1) begin : g_bad_lo
         $error("LO_LOG2 must be at least 1");
      end
      if (B_W < LO_LOG2 + 1) begin : g_bad_b
         $error("B_W too narrow for the high prescaler pair");
      end
      if (A_W < 4) begin : g_bad_a
         $error("main field too narrow for the reset default");
      end
   endgenerate

   logic           tc;
   logic           wrap;
   logic           long_nxt;
   logic           p_hi_q;
   logic           hi_nxt;
   logic [A_W-1:0] a_nxt;
   logic [B_W-1:0] b_nxt;

   pswal_cfg #(
      .A_HI_W (A_HI_W),
      .A_LO_W (A_LO_W),
      .B_W    (B_W),
      .LO_LOG2(LO_LOG2),
      .CLAMP  (CLAMP)
   ) u_cfg (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wrap_i  (wrap),
      .a_hi_i  (a_hi_i),
      .a_lo_i  (a_lo_i),
      .b_i     (swallow_i),
      .psel_i  (psel_i),
      .p_hi_q_o(p_hi_q),
      .hi_nxt_o(hi_nxt),
      .a_nxt_o (a_nxt),
      .b_nxt_o (b_nxt)
   );

   pswal_count #(
      .A_W(A_W),
      .B_W(B_W)
   ) u_count (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .tc_i      (tc),
      .a_ld_i    (a_nxt),
      .b_ld_i    (b_nxt),
      .wrap_o    (wrap),
      .long_nxt_o(long_nxt)
   );

   pswal_prescaler #(
      .LO_LOG2(LO_LOG2)
   ) u_pre (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ld_hi_i  (hi_nxt),
      .ld_long_i(long_nxt),
      .tc_o     (tc)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)
         pulse_o <= 1'b0;
      else
         pulse_o <= wrap;
   end

   a_r5_one_wide: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |=> !pulse_o);

   a_r6_quiet_in_reset: assert property (@(posedge clk_i)
      rst_i |=> !pulse_o);

   a_r7_pair_switch_on_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
      (p_hi_q != $past(p_hi_q)) |-> pulse_o);

endmodule

// File: tb/pswal_fbdiv_tb_top.sv
module pswal_fbdiv_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] a_hi = '0;
   logic [3:0] a_lo = '0;
   logic [3:0] sw = '0;
   logic       ps = 1'b0;
   logic       pulse;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   pswal_fbdiv dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .a_hi_i   (a_hi),
      .a_lo_i   (a_lo),
      .swallow_i(sw),
      .psel_i   (ps),
      .pulse_o  (pulse)
   );

   function automatic int exp_n(input int f, input int b, input bit hi);
      int p;
      int a;
      int be;
      p  = hi ? 16 : 8;
      a  = f + 1;
      be = (b > p - 1) ? p - 1 : b;
      if (be >= a) return a * (p + 1);
      return p * a + be;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input int f, input int b, input bit hi);
      {a_hi, a_lo} = 9'(f);
      sw = 4'(b);
      ps = hi;
   endtask

   // waits until pulse seen high at a falling edge
   task automatic wait_pulse();
      do @(negedge clk); while (!pulse);
   endtask

   // called right after a pulse was seen; returns clocks to the next one
   task automatic measure(output int n, input string tag);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) chk(!pulse, {tag, " R5 width"}, int'(pulse), 0);
      end while (!pulse);
   endtask

   task automatic run_cfg(input int f, input int b, input bit hi, input string tag);
      int n;
      drive(f, b, hi);
      wait_pulse();
      measure(n, tag);
      chk(n == exp_n(f, b, hi), tag, n, exp_n(f, b, hi));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      int m;
      int fl [7] = '{0, 1, 2, 3, 6, 12, 39};

      // R6: reset quiet, defaults used regardless of inputs
      drive(3, 1, 1'b0);
      repeat (6) begin
         @(negedge clk);
         chk(!pulse, "R6 reset quiet", int'(pulse), 0);
      end
      rst = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!pulse);
      chk(n == 212, "R6 first period", n, 212);
      // R7: inputs captured at that pulse
      measure(n, "R7 captured");
      chk(n == exp_n(3, 1, 1'b0), "R7 captured at pulse", n, exp_n(3, 1, 1'b0));

      // R1 R2 R4 sweep: both pairs, several A, all legal B
      for (int h = 0; h < 2; h++) begin
         for (int i = 0; i < 7; i++) begin
            for (int b = 0; b < (h != 0 ? 16 : 8); b++) begin
               run_cfg(fl[i], b, h[0], (b > fl[i]) ? "R4 sweep" : "R1 R2 sweep");
            end
         end
      end

      // R3: swallow above P-1 saturates
      run_cfg(12, 12, 1'b0, "R3 clamp b12");
      run_cfg(4, 15, 1'b0, "R3 clamp b15");

      // R4: B >= A still periodic
      run_cfg(1, 5, 1'b1, "R4 long only");
      measure(n, "R4 repeat");
      chk(n == 34, "R4 repeat period", n, 34);

      // R8: extremes of the main field
      run_cfg(511, 0, 1'b1, "R8 A512 b0");
      run_cfg(511, 15, 1'b1, "R8 A512 b15");
      run_cfg(0, 0, 1'b0, "R8 A1 b0");
      run_cfg(0, 3, 1'b0, "R8 A1 b3");

      // R7: change mid-period, old period completes
      run_cfg(20, 3, 1'b1, "R7 setup");
      repeat (100) @(negedge clk);
      drive(2, 1, 1'b0);
      m = 0;
      do begin
         @(negedge clk);
         m++;
      end while (!pulse);
      chk(m == exp_n(20, 3, 1'b1) - 100, "R7 no cut short", m, exp_n(20, 3, 1'b1) - 100);
      measure(n, "R7 new");
      chk(n == exp_n(2, 1, 1'b0), "R7 new period", n, exp_n(2, 1, 1'b0));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule